// File: doc/BRIEF.md
# Fractional Multiply-Accumulate with Four-Entry Accumulator Bank

This block multiplies two signed fractions and folds the product into one of four 64-bit accumulators. A 2-bit index picks the accumulator. Entry 0 stands in for the conventional single hi/lo product register of a 32-bit core, and entries 1 to 3 are additional. Operands are either 32-bit fractions (Q31), or 16-bit fractions (Q15) taken from the low half of each operand word. The product is shifted left by one to drop its redundant sign bit. It is then added to or subtracted from the chosen accumulator.

Every result that leaves the representable range is clamped to the nearest value that can be represented, and the accumulator's sticky overflow flag is set. The only way to clear that flag is a direct write to its accumulator. Software-visible loads of either 32-bit half of any accumulator go through a separate write port. A registered read port returns both halves of one selected accumulator.

An operation is accepted in the cycle `mac_valid` is high. Its product is registered at that edge, and the selected accumulator takes the result at the next edge.

Top module: `fracmac_bank`

## Requirements
- R1: After a synchronous reset, every accumulator reads zero, every overflow flag is clear, and both read outputs are zero.
- R2: With `mac_q15`=0, the product is the 64-bit value (signed `mac_a` × signed `mac_b`) shifted left by one. With `mac_sub`=0 this product is added to accumulator `mac_sel`.
- R3: With `mac_q15`=1, only bits 15:0 of each operand are used, and bits 31:16 have no effect. The product (signed×signed)<<1 is a 32-bit fraction, sign-extended to 64 bits.
- R4: With `mac_sub`=1, the product is subtracted from the selected accumulator instead of being added.
- R5: The product of -1 by -1 is clamped to the largest positive fraction: 0x7FFFFFFF_FFFFFFFF in Q31, and 0x00000000_7FFFFFFF in Q15 (0x7FFF in its top 16 fraction bits). This sets the target accumulator's overflow flag.
- R6: An add or subtract whose true result exceeds the signed 64-bit range writes 0x7FFFFFFF_FFFFFFFF or 0x80000000_00000000, whichever is nearer, and sets that accumulator's overflow flag.
- R7: An overflow flag (bit i of `ovf_flags` belongs to accumulator i) stays set through later non-overflowing operations. It is cleared only by an accepted write to that accumulator.
- R8: A write with `wr_upper`=1 replaces bits 63:32 of accumulator `wr_sel`, and with `wr_upper`=0 it replaces bits 31:0. The other half is left unchanged.
- R9: A write that lands in the same cycle as the accumulate update of the same accumulator is dropped. A write to a different accumulator in that cycle still takes effect.
- R10: An operation accepted at clock edge E updates the accumulator at edge E+1. The read outputs show accumulator `rd_sel` one edge after it is sampled, so the new value appears after edge E+2.
- R11: An operation changes only the selected accumulator. The other three keep their values and flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mac_valid | input | 1 | Accept an operation this cycle |
| mac_sub | input | 1 | 1 = subtract product, 0 = add |
| mac_q15 | input | 1 | 1 = Q15 operands (low 16 bits), 0 = Q31 |
| mac_sel | input | 2 | Target accumulator index |
| mac_a | input | 32 | Multiplicand |
| mac_b | input | 32 | Multiplier |
| wr_en | input | 1 | Direct half write |
| wr_upper | input | 1 | 1 = bits 63:32, 0 = bits 31:0 |
| wr_sel | input | 2 | Accumulator to write |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Accumulator to read |
| rd_upper | output | 32 | Registered bits 63:32 of the read accumulator |
| rd_lower | output | 32 | Registered bits 31:0 of the read accumulator |
| ovf_flags | output | 4 | Sticky overflow flag per accumulator |

## Verification
The product path is swept over every pair drawn from eight boundary operands in each format: the most negative value, the most negative value plus one, -1/2, -1 LSB, zero, +1 LSB, +1/2 and the largest positive value. The sweep alternates between add and subtract and rotates through all four accumulators. Junk in the ignored upper half of Q15 operands shows whether the wrong half is used. The -1 by -1 pairs separate a clamped product from a wrapped one. The accumulators are preloaded near both 64-bit limits so that adder clamping can be told apart from product clamping. A flag is then watched across a following non-overflowing operation and across a write, which separates a sticky flag from a freshly computed one. Writes are aimed at the update cycle both of the same accumulator and of a different one, which shows the priority. The read output is sampled on both edges after an operation to pin down the latency.

// File: rtl/fracmac_pkg.sv
package fracmac_pkg;
  typedef enum logic {FMT_Q31 = 1'b0, FMT_Q15 = 1'b1} frac_fmt_e;
  typedef enum logic {DIR_ADD = 1'b0, DIR_SUB = 1'b1} mac_dir_e;
endpackage

// File: rtl/fracmac_mul.sv
module fracmac_mul
  import fracmac_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ACC_W  = 2 * DATA_W,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sub,
  input  logic              in_q15,
  input  logic [IDX_W-1:0]  in_sel,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  output logic              st_valid,
  output logic              st_sub,
  output logic [IDX_W-1:0]  st_sel,
  output logic [ACC_W-1:0]  st_prod,
  output logic              st_sat
);
  localparam int HALF_W = DATA_W / 2;
  localparam logic [HALF_W-1:0] MIN_H = {1'b1, {(HALF_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] MIN_F = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [ACC_W-1:0]  MAX_F = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0]  MAX_H = {{(ACC_W-DATA_W){1'b0}}, 1'b0, {(DATA_W-1){1'b1}}};

  frac_fmt_e        fmt;
  logic [ACC_W-1:0] ext_a, ext_b, raw, aligned;
  logic             both_min;

  assign fmt = frac_fmt_e'(in_q15);

  always_comb begin
    if (fmt == FMT_Q15) begin
      ext_a    = {{(ACC_W-HALF_W){in_a[HALF_W-1]}}, in_a[HALF_W-1:0]};
      ext_b    = {{(ACC_W-HALF_W){in_b[HALF_W-1]}}, in_b[HALF_W-1:0]};
      both_min = (in_a[HALF_W-1:0] == MIN_H) && (in_b[HALF_W-1:0] == MIN_H);
    end else begin
      ext_a    = {{(ACC_W-DATA_W){in_a[DATA_W-1]}}, in_a};
      ext_b    = {{(ACC_W-DATA_W){in_b[DATA_W-1]}}, in_b};
      both_min = (in_a == MIN_F) && (in_b == MIN_F);
    end
    raw     = ext_a * ext_b;
    aligned = raw << 1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_valid <= 1'b0;
      st_sub   <= 1'b0;
      st_sel   <= '0;
      st_prod  <= '0;
      st_sat   <= 1'b0;
    end else begin
      st_valid <= in_valid;
      if (in_valid) begin
        st_sub  <= in_sub;
        st_sel  <= in_sel;
        st_sat  <= both_min;
        st_prod <= both_min ? ((fmt == FMT_Q15) ? MAX_H : MAX_F) : aligned;
      end
    end
  end

  // R5: minus one squared clamps to the largest positive Q31 fraction
  p_min_square_clamp_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_q15 && in_a == MIN_F && in_b == MIN_F)
      |=> (st_valid && st_sat && st_prod == MAX_F));

  // R3: a Q15 product always fits a sign-extended 32-bit fraction
  p_q15_range_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_q15)
      |=> (st_prod[ACC_W-1:DATA_W] == {(ACC_W-DATA_W){st_prod[DATA_W-1]}}));
endmodule

// File: rtl/fracmac_addsat.sv
module fracmac_addsat
  import fracmac_pkg::*;
#(
  parameter int ACC_W = 64
) (
  input  logic [ACC_W-1:0] acc_in,
  input  logic [ACC_W-1:0] prod,
  input  logic             sub,
  output logic [ACC_W-1:0] acc_out,
  output logic             ovf
);
  localparam logic [ACC_W-1:0] POS_LIM = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] NEG_LIM = {1'b1, {(ACC_W-1){1'b0}}};

  mac_dir_e   dir;
  logic [ACC_W:0] wide_acc, wide_prod, wide_sum;

  assign dir       = mac_dir_e'(sub);
  assign wide_acc  = {acc_in[ACC_W-1], acc_in};
  assign wide_prod = {prod[ACC_W-1], prod};

  always_comb begin
    wide_sum = (dir == DIR_SUB) ? (wide_acc - wide_prod) : (wide_acc + wide_prod);
    ovf      = wide_sum[ACC_W] ^ wide_sum[ACC_W-1];
    if (!ovf)               acc_out = wide_sum[ACC_W-1:0];
    else if (wide_sum[ACC_W]) acc_out = NEG_LIM;
    else                    acc_out = POS_LIM;
  end
endmodule

// File: rtl/fracmac_accbank.sv
module fracmac_accbank #(
  parameter int DATA_W  = 32,
  parameter int ACC_W   = 2 * DATA_W,
  parameter int NUM_ACC = 4,
  parameter int IDX_W   = $clog2(NUM_ACC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               st_valid,
  input  logic               st_sub,
  input  logic [IDX_W-1:0]   st_sel,
  input  logic [ACC_W-1:0]   st_prod,
  input  logic               st_sat,
  input  logic               wr_en,
  input  logic               wr_upper,
  input  logic [IDX_W-1:0]   wr_sel,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [IDX_W-1:0]   rd_sel,
  output logic [DATA_W-1:0]  rd_upper,
  output logic [DATA_W-1:0]  rd_lower,
  output logic [NUM_ACC-1:0] ovf_flags
);
  logic [ACC_W-1:0] acc_q [NUM_ACC];
  logic [ACC_W-1:0] upd_val;
  logic             upd_ovf;

  fracmac_addsat #(.ACC_W(ACC_W)) u_addsat (
    .acc_in  (acc_q[st_sel]),
    .prod    (st_prod),
    .sub     (st_sub),
    .acc_out (upd_val),
    .ovf     (upd_ovf)
  );

  for (genvar i = 0; i < NUM_ACC; i++) begin : g_acc
    logic hit_mac, hit_wr;
    assign hit_mac = st_valid && (st_sel == IDX_W'(i));
    assign hit_wr  = wr_en && (wr_sel == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        acc_q[i]     <= '0;
        ovf_flags[i] <= 1'b0;
      end else if (hit_mac) begin
        acc_q[i]     <= upd_val;
        ovf_flags[i] <= ovf_flags[i] | upd_ovf | st_sat;
      end else if (hit_wr) begin
        if (wr_upper) acc_q[i][ACC_W-1:DATA_W] <= wr_data;
        else          acc_q[i][DATA_W-1:0]     <= wr_data;
        ovf_flags[i] <= 1'b0;
      end
    end

    // R7: flag persists unless its accumulator is written
    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
      (ovf_flags[i] && !(wr_en && wr_sel == IDX_W'(i))) |=> ovf_flags[i]);

    // R9: a write colliding with the update of the same entry is lost
    p_write_dropped_r9: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_sel == IDX_W'(i) && st_valid && st_sel == IDX_W'(i) && !st_sat
       && acc_q[i] == '0 && st_prod == '0 && wr_data != '0)
        |=> (acc_q[i] == '0));

    // R11: idle entries hold their value
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
      (!(st_valid && st_sel == IDX_W'(i)) && !(wr_en && wr_sel == IDX_W'(i)))
        |=> ($stable(acc_q[i]) && $stable(ovf_flags[i])));

    // R8: a lone upper write leaves the lower half intact
    p_half_write_r8: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_upper && wr_sel == IDX_W'(i) && !(st_valid && st_sel == IDX_W'(i)))
        |=> (acc_q[i][ACC_W-1:DATA_W] == $past(wr_data)
             && acc_q[i][DATA_W-1:0] == $past(acc_q[i][DATA_W-1:0])));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_upper <= '0;
      rd_lower <= '0;
    end else begin
      rd_upper <= acc_q[rd_sel][ACC_W-1:DATA_W];
      rd_lower <= acc_q[rd_sel][DATA_W-1:0];
    end
  end
endmodule

// File: rtl/fracmac_bank.sv
module fracmac_bank #(
  parameter int DATA_W  = 32,
  parameter int NUM_ACC = 4,
  parameter int IDX_W   = $clog2(NUM_ACC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mac_valid,
  input  logic               mac_sub,
  input  logic               mac_q15,
  input  logic [IDX_W-1:0]   mac_sel,
  input  logic [DATA_W-1:0]  mac_a,
  input  logic [DATA_W-1:0]  mac_b,
  input  logic               wr_en,
  input  logic               wr_upper,
  input  logic [IDX_W-1:0]   wr_sel,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [IDX_W-1:0]   rd_sel,
  output logic [DATA_W-1:0]  rd_upper,
  output logic [DATA_W-1:0]  rd_lower,
  output logic [NUM_ACC-1:0] ovf_flags
);
  localparam int ACC_W = 2 * DATA_W;

  logic             st_valid, st_sub, st_sat;
  logic [IDX_W-1:0] st_sel;
  logic [ACC_W-1:0] st_prod;

  fracmac_mul #(.DATA_W(DATA_W), .ACC_W(ACC_W), .IDX_W(IDX_W)) u_mul (
    .clk      (clk),
    .rst      (rst),
    .in_valid (mac_valid),
    .in_sub   (mac_sub),
    .in_q15   (mac_q15),
    .in_sel   (mac_sel),
    .in_a     (mac_a),
    .in_b     (mac_b),
    .st_valid (st_valid),
    .st_sub   (st_sub),
    .st_sel   (st_sel),
    .st_prod  (st_prod),
    .st_sat   (st_sat)
  );

  fracmac_accbank #(.DATA_W(DATA_W), .ACC_W(ACC_W), .NUM_ACC(NUM_ACC), .IDX_W(IDX_W)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .st_valid  (st_valid),
    .st_sub    (st_sub),
    .st_sel    (st_sel),
    .st_prod   (st_prod),
    .st_sat    (st_sat),
    .wr_en     (wr_en),
    .wr_upper  (wr_upper),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .rd_sel    (rd_sel),
    .rd_upper  (rd_upper),
    .rd_lower  (rd_lower),
    .ovf_flags (ovf_flags)
  );

  // R1: flags are clear right after reset is released
  p_reset_clear_r1: assert property (@(posedge clk)
    $fell(rst) |-> (ovf_flags == '0));

  // R6: a newly raised flag comes from an operation, never from a write
  p_flag_source_r6: assert property (@(posedge clk) disable iff (rst)
    (ovf_flags != $past(ovf_flags) && $countones(ovf_flags) > $countones($past(ovf_flags)))
      |-> $past(st_valid));
endmodule

// File: tb/fracmac_bank_tb_top.sv
module fracmac_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        mac_valid, mac_sub, mac_q15;
  logic [1:0]  mac_sel;
  logic [31:0] mac_a, mac_b;
  logic        wr_en, wr_upper;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data;
  logic [1:0]  rd_sel;
  logic [31:0] rd_upper, rd_lower;
  logic [3:0]  ovf_flags;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [63:0] acc_m [4];
  logic [3:0]  ovf_m;

  always #10 clk = ~clk;

  fracmac_bank dut_i (
    .clk(clk), .rst(rst), .mac_valid(mac_valid), .mac_sub(mac_sub), .mac_q15(mac_q15),
    .mac_sel(mac_sel), .mac_a(mac_a), .mac_b(mac_b), .wr_en(wr_en), .wr_upper(wr_upper),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_upper(rd_upper),
    .rd_lower(rd_lower), .ovf_flags(ovf_flags)
  );

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [63:0] ref_prod(logic q15, logic [31:0] a, logic [31:0] b,
                                            output logic sat);
    longint pa, pb;
    sat = 1'b0;
    if (q15) begin
      pa = longint'($signed(a[15:0]));
      pb = longint'($signed(b[15:0]));
      if (pa == -32768 && pb == -32768) begin sat = 1'b1; return 64'h0000_0000_7FFF_FFFF; end
    end else begin
      pa = longint'($signed(a));
      pb = longint'($signed(b));
      if (a == 32'h8000_0000 && b == 32'h8000_0000) begin sat = 1'b1; return 64'h7FFF_FFFF_FFFF_FFFF; end
    end
    return 64'(pa * pb * 2);
  endfunction

  task automatic model_mac(logic sub, logic q15, logic [1:0] sel, logic [31:0] a, logic [31:0] b);
    logic sat;
    logic [63:0] p;
    logic signed [64:0] s;
    p = ref_prod(q15, a, b, sat);
    if (sub) s = $signed({acc_m[sel][63], acc_m[sel]}) - $signed({p[63], p});
    else     s = $signed({acc_m[sel][63], acc_m[sel]}) + $signed({p[63], p});
    if (s[64] != s[63]) begin
      sat = 1'b1;
      acc_m[sel] = s[64] ? 64'h8000_0000_0000_0000 : 64'h7FFF_FFFF_FFFF_FFFF;
    end else acc_m[sel] = s[63:0];
    if (sat) ovf_m[sel] = 1'b1;
  endtask

  task automatic mac(logic sub, logic q15, logic [1:0] sel, logic [31:0] a, logic [31:0] b);
    @(negedge clk);
    mac_valid = 1'b1; mac_sub = sub; mac_q15 = q15; mac_sel = sel; mac_a = a; mac_b = b;
    @(negedge clk);
    mac_valid = 1'b0;
    model_mac(sub, q15, sel, a, b);
    @(negedge clk);
  endtask

  task automatic wr(logic [1:0] sel, logic up, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_upper = up; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (up) acc_m[sel][63:32] = d; else acc_m[sel][31:0] = d;
    ovf_m[sel] = 1'b0;
  endtask

  task automatic check_acc(string tag, logic [1:0] sel);
    @(negedge clk);
    rd_sel = sel;
    @(negedge clk);
    chk(tag, {rd_upper, rd_lower}, acc_m[sel]);
    chk({tag, " flags"}, 64'(ovf_flags), 64'(ovf_m));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v16 [8];
    logic [31:0] v32 [8];
    v16 = '{16'h8000, 16'h8001, 16'hC000, 16'hFFFF, 16'h0000, 16'h0001, 16'h4000, 16'h7FFF};
    v32 = '{32'h8000_0000, 32'h8000_0001, 32'hC000_0000, 32'hFFFF_FFFF,
            32'h0000_0000, 32'h0000_0001, 32'h4000_0000, 32'h7FFF_FFFF};
    rst = 1'b1; mac_valid = 0; mac_sub = 0; mac_q15 = 0; mac_sel = 0; mac_a = 0; mac_b = 0;
    wr_en = 0; wr_upper = 0; wr_sel = 0; wr_data = 0; rd_sel = 0;
    for (int i = 0; i < 4; i++) acc_m[i] = '0;
    ovf_m = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state of every entry
    for (int i = 0; i < 4; i++) check_acc("R1 reset", 2'(i));

    // R10 latency: accept at edge E, read shows new value only after E+2
    @(negedge clk);
    rd_sel = 2'd1;
    mac_valid = 1'b1; mac_sub = 0; mac_q15 = 0; mac_sel = 2'd1;
    mac_a = 32'h4000_0000; mac_b = 32'h4000_0000;
    @(negedge clk);
    mac_valid = 1'b0;
    chk("R10 after E", {rd_upper, rd_lower}, 64'd0);
    @(negedge clk);
    chk("R10 after E+1", {rd_upper, rd_lower}, 64'd0);
    @(negedge clk);
    chk("R10 after E+2", {rd_upper, rd_lower}, 64'h2000_0000_0000_0000);
    model_mac(1'b0, 1'b0, 2'd1, 32'h4000_0000, 32'h4000_0000);

    // R3 R4 R5 Q15 sweep with junk in the ignored upper half
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) begin
        mac(1'((i + j) % 2), 1'b1, 2'((i + j) % 4), {16'hA5A5 ^ 16'(i), v16[i]}, {16'h5A5A, v16[j]});
        check_acc("R3 R4 R5 q15 sweep", 2'((i + j) % 4));
      end

    // R2 R4 R5 R6 Q31 sweep
    for (int i = 0; i < 4; i++) wr(2'(i), 1'b1, 32'h0);
    for (int i = 0; i < 4; i++) wr(2'(i), 1'b0, 32'h0);
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) begin
        mac(1'(i % 2), 1'b0, 2'(j % 4), v32[i], v32[j]);
        check_acc("R2 R4 R5 R6 q31 sweep", 2'(j % 4));
      end

    // R11 all entries after sweeps
    for (int i = 0; i < 4; i++) check_acc("R11 all entries", 2'(i));

    // R6 positive clamp, R7 sticky then cleared
    wr(2'd2, 1'b1, 32'h7FFF_FFFF);
    wr(2'd2, 1'b0, 32'hFFFF_FFFF);
    check_acc("R8 preload", 2'd2);
    mac(1'b0, 1'b0, 2'd2, 32'h4000_0000, 32'h4000_0000);
    check_acc("R6 positive clamp", 2'd2);
    mac(1'b1, 1'b0, 2'd2, 32'h0000_0001, 32'h0000_0001);
    check_acc("R7 flag stays", 2'd2);
    wr(2'd2, 1'b0, 32'h1234_5678);
    check_acc("R7 R8 flag cleared by write", 2'd2);

    // R6 negative clamp
    wr(2'd0, 1'b1, 32'h8000_0000);
    wr(2'd0, 1'b0, 32'h0000_0000);
    mac(1'b1, 1'b1, 2'd0, 32'h0000_4000, 32'h0000_4000);
    check_acc("R6 negative clamp", 2'd0);

    // R5 Q15 minus one squared into a clean entry
    wr(2'd1, 1'b1, 32'h0); wr(2'd1, 1'b0, 32'h0);
    mac(1'b0, 1'b1, 2'd1, 32'hFFFF_8000, 32'h0000_8000);
    check_acc("R5 q15 clamp", 2'd1);

    // R9 write in the update cycle of the same entry is dropped; other entry written
    wr(2'd3, 1'b1, 32'h0); wr(2'd3, 1'b0, 32'h0);
    @(negedge clk);
    mac_valid = 1'b1; mac_sub = 1'b0; mac_q15 = 1'b0; mac_sel = 2'd3;
    mac_a = 32'h2000_0000; mac_b = 32'h4000_0000;
    @(negedge clk);
    mac_valid = 1'b0;
    wr_en = 1'b1; wr_sel = 2'd3; wr_upper = 1'b1; wr_data = 32'hDEAD_BEEF;
    @(negedge clk);
    wr_en = 1'b0;
    model_mac(1'b0, 1'b0, 2'd3, 32'h2000_0000, 32'h4000_0000);
    check_acc("R9 same entry write dropped", 2'd3);
    @(negedge clk);
    mac_valid = 1'b1; mac_sub = 1'b0; mac_q15 = 1'b0; mac_sel = 2'd3;
    mac_a = 32'h2000_0000; mac_b = 32'h4000_0000;
    @(negedge clk);
    mac_valid = 1'b0;
    wr_en = 1'b1; wr_sel = 2'd1; wr_upper = 1'b0; wr_data = 32'hCAFE_0001;
    @(negedge clk);
    wr_en = 1'b0;
    model_mac(1'b0, 1'b0, 2'd3, 32'h2000_0000, 32'h4000_0000);
    acc_m[1][31:0] = 32'hCAFE_0001;
    ovf_m[1] = 1'b0;
    check_acc("R9 other entry written", 2'd1);
    check_acc("R9 R11 target entry", 2'd3);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule